// File: doc/BRIEF.md
# Multi-Source System Reset Sequencer

This block produces the internal reset of a microcontroller from three sources: the external active-low reset pin, a one-cycle software reset request and a one-cycle watchdog overflow. Reset from the pin is entered asynchronously and needs no clock. The release of the pin passes through a synchronizer before the block leaves the pin phase. Every source then runs the same fixed-length internal reset sequence, counted in CPU clock cycles. At the end of the sequence the block samples the pin again and keeps reset asserted while something outside still holds the pin low.

Each source treats the external bus in its own way. After a warm pin release (mode pin high), a transition phase aborts any running bus cycle before the sequence begins. A watchdog overflow waits for the running bus cycle: it lets the cycle finish if the cycle does not use READY or if READY is sampled active, and it aborts the cycle if READY is sampled inactive. A software reset always pulls the pin low through the open-drain enable for the whole sequence. A watchdog reset does so only when the bidirectional enable has been set, and that enable is cleared at the end of every sequence. While the block drives the pin itself, a shield keeps its own pin drive from re-entering the asynchronous reset path.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `pin_rst_n_i` is low and the block is not driving the pin itself, `sys_rst_o`=1, `rstout_n_o`=0, `pin_drive_o`=0 and `bus_abort_o`=0, without any clock edge.
- R2: After the pin goes high, a cold release (`warm_mode_i`=0) holds `sys_rst_o` for SEQ_CYCLES+2*SYNC_STAGES+2 rising edges: SYNC_STAGES+1 to detect the release, SEQ_CYCLES of sequence and SYNC_STAGES+1 to settle. `sys_rst_o` falls only when the synchronized pin reads high.
- R3: A warm release (`warm_mode_i`=1) first runs a transition phase with `bus_abort_o`=1 for exactly TRANS_CYCLES cycles, and that phase adds TRANS_CYCLES to the reset time. A cold release never raises `bus_abort_o`.
- R4: Any sequence lasts SEQ_CYCLES cycles plus the SYNC_STAGES+1 settle cycles. A software or immediate watchdog reset therefore holds `sys_rst_o` for SEQ_CYCLES+SYNC_STAGES+1 cycles after the sampling edge.
- R5: A `sw_req_i` pulse seen while running raises `sys_rst_o` and `pin_drive_o` on the next edge. `pin_drive_o` stays high for exactly SEQ_CYCLES cycles, whatever the bidirectional enable holds.
- R6: A `wdt_ovf_i` pulse with no bus cycle running (`bus_busy_i`=0) starts the sequence on the next edge. With the bidirectional enable clear, `pin_drive_o` stays 0.
- R7: A watchdog overflow during a bus cycle (`bus_busy_i`=1) waits until `bus_ws_done_i`=1, with `sys_rst_o` still 0. If `bus_rdy_used_i`=1 and `rdy_n_i`=1 at that point, `bus_abort_o` pulses for exactly one cycle; otherwise it stays 0. The sequence starts on that edge.
- R8: A watchdog overflow while `boot_mode_i`=1 is ignored, and `sys_rst_o` stays 0.
- R9: A `bidir_set_i` pulse makes the next watchdog sequence drive `pin_drive_o` for SEQ_CYCLES cycles. The enable clears when any sequence ends, so a later watchdog reset does not drive the pin.
- R10: If the pin is still held low externally when the settle phase ends, `sys_rst_o` stays 1 until the synchronized pin reads high. It falls on the (SYNC_STAGES+1)-th edge after release.
- R11: Software or watchdog requests that arrive during a running reset are absorbed, and the sequence length is unchanged.
- R12: When `sw_req_i` and `wdt_ovf_i` arrive in the same cycle, the software reset wins and the pin is driven even with the bidirectional enable clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| pin_rst_n_i | input | 1 | Level seen on the reset pin, active low |
| pin_drive_o | output | 1 | Open-drain enable, 1 pulls the reset pin low |
| warm_mode_i | input | 1 | Mode pin, 1 selects warm pin reset with bus-abort transition |
| bidir_set_i | input | 1 | Pulse that sets the bidirectional-reset enable |
| sw_req_i | input | 1 | Software reset request pulse |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse |
| boot_mode_i | input | 1 | Bootstrap-mode flag, blocks watchdog resets |
| bus_busy_i | input | 1 | An external bus cycle is running |
| bus_rdy_used_i | input | 1 | The running bus cycle uses READY |
| bus_ws_done_i | input | 1 | Programmed wait states of the running cycle have elapsed |
| rdy_n_i | input | 1 | READY, active low |
| bus_abort_o | output | 1 | Abort the running external bus cycle |
| rstout_n_o | output | 1 | Reset-out indicator, active low |
| sys_rst_o | output | 1 | Internal system reset, active high |

## Verification
The bench builds the block with SEQ_CYCLES=16, TRANS_CYCLES=4 and SYNC_STAGES=2, so a whole sequence, its settle window and the warm transition each fit in a few dozen cycles. Many complete resets then run in one short test. These values bring the counter wrap at the last sequence cycle and the three-edge settle and hold decisions into reach. The same run covers watchdog waits on a bus cycle, an external pin hold that starts while the block drives the pin, and requests absorbed in mid-sequence.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_PIN    = 3'd1,
        ST_TRANS  = 3'd2,
        ST_WAIT   = 3'd3,
        ST_SEQ    = 3'd4,
        ST_SETTLE = 3'd5,
        ST_HOLD   = 3'd6
    } rs_state_e;

endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain_q[0] <= 1'b0;
                else         chain_q[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain_q[i] <= 1'b0;
                else         chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/rst_bus_gate.sv
module rst_bus_gate (
    input  logic busy_i,
    input  logic rdy_used_i,
    input  logic ws_done_i,
    input  logic rdy_n_i,
    output logic go_o,
    output logic kill_o
);

    // Sequence may start once no cycle runs or the running one reaches its last wait state.
    assign go_o   = !busy_i || ws_done_i;
    // A READY-controlled cycle that sees READY inactive at that point is aborted.
    assign kill_o = busy_i && ws_done_i && rdy_used_i && rdy_n_i;

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int SEQ_CYCLES   = 512,
    parameter int TRANS_CYCLES = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic pin_rst_n_i,
    output logic pin_drive_o,
    input  logic warm_mode_i,
    input  logic bidir_set_i,
    input  logic sw_req_i,
    input  logic wdt_ovf_i,
    input  logic boot_mode_i,
    input  logic bus_busy_i,
    input  logic bus_rdy_used_i,
    input  logic bus_ws_done_i,
    input  logic rdy_n_i,
    output logic bus_abort_o,
    output logic rstout_n_o,
    output logic sys_rst_o
);

    localparam int SETTLE_CYCLES = SYNC_STAGES + 1;
    localparam int CNT_W         = $clog2(SEQ_CYCLES);
    localparam logic [CNT_W-1:0] SEQ_LAST    = CNT_W'(SEQ_CYCLES - 1);
    localparam logic [CNT_W-1:0] TRANS_LAST  = CNT_W'(TRANS_CYCLES - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);

    typedef struct packed {
        rs_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic             drive;
        logic             shield;
        logic             rst;
        logic             abort;
        logic             bidir;
    } seq_regs_t;

    localparam seq_regs_t RST_VAL = '{
        state:  ST_PIN,
        cnt:    '0,
        drive:  1'b0,
        shield: 1'b0,
        rst:    1'b1,
        abort:  1'b0,
        bidir:  1'b0
    };

    seq_regs_t r_q, r_d;
    logic      arst_n;
    logic      pin_hi;
    logic      bus_go;
    logic      bus_kill;

    // Own pin drive must not feed back into the asynchronous entry path.
    assign arst_n = pin_rst_n_i | r_q.shield;

    rst_pin_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d      (pin_rst_n_i),
        .q      (pin_hi)
    );

    rst_bus_gate u_gate (
        .busy_i     (bus_busy_i),
        .rdy_used_i (bus_rdy_used_i),
        .ws_done_i  (bus_ws_done_i),
        .rdy_n_i    (rdy_n_i),
        .go_o       (bus_go),
        .kill_o     (bus_kill)
    );

    always_comb begin
        r_d       = r_q;
        r_d.abort = 1'b0;
        r_d.bidir = r_q.bidir | bidir_set_i;

        unique case (r_q.state)
            ST_RUN: begin
                if (sw_req_i) begin
                    r_d.state  = ST_SEQ;
                    r_d.cnt    = '0;
                    r_d.drive  = 1'b1;
                    r_d.shield = 1'b1;
                    r_d.rst    = 1'b1;
                end else if (wdt_ovf_i && !boot_mode_i) begin
                    if (bus_go) begin
                        r_d.state  = ST_SEQ;
                        r_d.cnt    = '0;
                        r_d.drive  = r_q.bidir;
                        r_d.shield = r_q.bidir;
                        r_d.rst    = 1'b1;
                        r_d.abort  = bus_kill;
                    end else begin
                        r_d.state = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (bus_go) begin
                    r_d.state  = ST_SEQ;
                    r_d.cnt    = '0;
                    r_d.drive  = r_q.bidir;
                    r_d.shield = r_q.bidir;
                    r_d.rst    = 1'b1;
                    r_d.abort  = bus_kill;
                end
            end
            ST_PIN: begin
                if (pin_hi) begin
                    r_d.cnt = '0;
                    if (warm_mode_i) begin
                        r_d.state = ST_TRANS;
                        r_d.abort = 1'b1;
                    end else begin
                        r_d.state = ST_SEQ;
                    end
                end
            end
            ST_TRANS: begin
                if (r_q.cnt == TRANS_LAST) begin
                    r_d.state = ST_SEQ;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt   = r_q.cnt + CNT_W'(1);
                    r_d.abort = 1'b1;
                end
            end
            ST_SEQ: begin
                if (r_q.cnt == SEQ_LAST) begin
                    r_d.state = ST_SETTLE;
                    r_d.cnt   = '0;
                    r_d.drive = 1'b0;
                    r_d.bidir = 1'b0;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_SETTLE: begin
                if (r_q.cnt == SETTLE_LAST) begin
                    r_d.cnt = '0;
                    if (pin_hi) begin
                        r_d.state  = ST_RUN;
                        r_d.rst    = 1'b0;
                        r_d.shield = 1'b0;
                    end else begin
                        r_d.state = ST_HOLD;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_HOLD: begin
                if (pin_hi) begin
                    r_d.state  = ST_RUN;
                    r_d.rst    = 1'b0;
                    r_d.shield = 1'b0;
                end
            end
            default: begin
                r_d = RST_VAL;
            end
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) r_q <= RST_VAL;
        else         r_q <= r_d;
    end

    assign sys_rst_o   = r_q.rst;
    assign rstout_n_o  = ~r_q.rst;
    assign pin_drive_o = r_q.drive;
    assign bus_abort_o = r_q.abort;

endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk
    import rst_seq_pkg::*;
#(
    parameter int CNT_W      = 9,
    parameter int SEQ_CYCLES = 512
) (
    input logic             clk,
    input logic             arst_n,
    input rs_state_e        state_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             bidir_q,
    input logic             pin_hi,
    input logic             sw_req_i,
    input logic             wdt_ovf_i,
    input logic             boot_mode_i,
    input logic             sys_rst_o,
    input logic             pin_drive_o,
    input logic             bus_abort_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(SEQ_CYCLES - 1);

    always @(posedge clk) begin
        if (arst_n === 1'b0) begin
            p_async_entry_r1: assert (sys_rst_o && !pin_drive_o && !bus_abort_o)
                else $error("p_async_entry_r1");
        end
    end

    p_release_sync_r2: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(sys_rst_o) |-> $past(pin_hi));

    p_drive_in_rst_r5: assert property (@(posedge clk) disable iff (!arst_n)
        pin_drive_o |-> sys_rst_o);

    p_sw_start_r5: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == ST_RUN && sw_req_i) |=> (sys_rst_o && pin_drive_o));

    p_abort_pulse_r7: assert property (@(posedge clk) disable iff (!arst_n)
        (bus_abort_o && state_q == ST_SEQ) |=> !bus_abort_o);

    p_boot_block_r8: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == ST_RUN && wdt_ovf_i && boot_mode_i && !sw_req_i) |=> !sys_rst_o);

    p_bidir_clear_r9: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == ST_SEQ && cnt_q == LAST) |=> (!bidir_q && !pin_drive_o));

    p_hold_r10: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == ST_HOLD && !pin_hi) |=> sys_rst_o);

    p_absorb_r11: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == ST_SEQ && cnt_q != LAST) |=> (state_q == ST_SEQ && sys_rst_o));

endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk #(
    .CNT_W      (CNT_W),
    .SEQ_CYCLES (SEQ_CYCLES)
) u_chk (
    .clk         (clk),
    .arst_n      (arst_n),
    .state_q     (r_q.state),
    .cnt_q       (r_q.cnt),
    .bidir_q     (r_q.bidir),
    .pin_hi      (pin_hi),
    .sw_req_i    (sw_req_i),
    .wdt_ovf_i   (wdt_ovf_i),
    .boot_mode_i (boot_mode_i),
    .sys_rst_o   (sys_rst_o),
    .pin_drive_o (pin_drive_o),
    .bus_abort_o (bus_abort_o)
);

// File: tb/tb_rst_seq_ctrl.sv
module tb_rst_seq_ctrl;

    localparam int SEQ = 16;
    localparam int TRN = 4;

    localparam int PH_RUN  = 0;
    localparam int PH_PIN  = 1;
    localparam int PH_TRN  = 2;
    localparam int PH_WAIT = 3;
    localparam int PH_SEQ  = 4;
    localparam int PH_SET  = 5;
    localparam int PH_HOLD = 6;

    logic clk = 1'b0;
    logic ext_n = 1'b1;
    logic warm_mode = 1'b0, bidir_set = 1'b0, sw_req = 1'b0, wdt_ovf = 1'b0;
    logic boot_mode = 1'b0, bus_busy = 1'b0, bus_rdy_used = 1'b0;
    logic bus_ws_done = 1'b0, rdy_n = 1'b0;
    logic pin_drive, bus_abort, rstout_n, sys_rst;
    logic pad;

    int checks = 0;
    int errors = 0;
    int n_rst = 0, n_drv = 0, n_abt = 0;

    // model state
    int m_ph, m_rem;
    bit m_s0, m_s1, m_drv, m_shd, m_rst, m_abt, m_bid;
    bit m_on = 1'b0;

    always #4 clk = ~clk;

    // wired-AND reset pin: external driver and the block's open-drain pull
    assign pad = ext_n & ~pin_drive;

    rst_seq_ctrl #(
        .SEQ_CYCLES   (SEQ),
        .TRANS_CYCLES (TRN),
        .SYNC_STAGES  (2)
    ) dut (
        .clk            (clk),
        .pin_rst_n_i    (pad),
        .pin_drive_o    (pin_drive),
        .warm_mode_i    (warm_mode),
        .bidir_set_i    (bidir_set),
        .sw_req_i       (sw_req),
        .wdt_ovf_i      (wdt_ovf),
        .boot_mode_i    (boot_mode),
        .bus_busy_i     (bus_busy),
        .bus_rdy_used_i (bus_rdy_used),
        .bus_ws_done_i  (bus_ws_done),
        .rdy_n_i        (rdy_n),
        .bus_abort_o    (bus_abort),
        .rstout_n_o     (rstout_n),
        .sys_rst_o      (sys_rst)
    );

    task automatic m_reset();
        m_ph = PH_PIN; m_rem = 0; m_s0 = 0; m_s1 = 0;
        m_drv = 0; m_shd = 0; m_rst = 1; m_abt = 0; m_bid = 0;
    endtask

    task automatic m_start(input bit drv, input bit abt);
        m_ph = PH_SEQ; m_rem = SEQ - 1; m_drv = drv; m_shd = drv;
        m_rst = 1; m_abt = abt;
    endtask

    always @(negedge ext_n) if (m_on && !m_shd) m_reset();

    always @(posedge clk) begin : ref_model
        bit p, o_s1, o_bid, go, kill;
        if (m_on) begin
            if (!ext_n && !m_shd) begin
                m_reset();
            end else begin
                p = ext_n && !m_drv;
                o_s1 = m_s1; o_bid = m_bid;
                m_s1 = m_s0; m_s0 = p;
                go = !bus_busy || bus_ws_done;
                kill = bus_busy && bus_ws_done && bus_rdy_used && rdy_n;
                m_abt = 0;
                if (bidir_set) m_bid = 1;
                case (m_ph)
                    PH_RUN: begin
                        if (sw_req) m_start(1'b1, 1'b0);
                        else if (wdt_ovf && !boot_mode) begin
                            if (go) m_start(o_bid, kill);
                            else m_ph = PH_WAIT;
                        end
                    end
                    PH_WAIT: if (go) m_start(o_bid, kill);
                    PH_PIN: begin
                        if (o_s1) begin
                            if (warm_mode) begin m_ph = PH_TRN; m_rem = TRN - 1; m_abt = 1; end
                            else begin m_ph = PH_SEQ; m_rem = SEQ - 1; end
                        end
                    end
                    PH_TRN: begin
                        if (m_rem == 0) begin m_ph = PH_SEQ; m_rem = SEQ - 1; end
                        else begin m_rem--; m_abt = 1; end
                    end
                    PH_SEQ: begin
                        if (m_rem == 0) begin m_ph = PH_SET; m_rem = 2; m_drv = 0; m_bid = 0; end
                        else m_rem--;
                    end
                    PH_SET: begin
                        if (m_rem == 0) begin
                            if (o_s1) begin m_ph = PH_RUN; m_rst = 0; m_shd = 0; end
                            else m_ph = PH_HOLD;
                        end else m_rem--;
                    end
                    default: begin
                        if (o_s1) begin m_ph = PH_RUN; m_rst = 0; m_shd = 0; end
                    end
                endcase
            end
        end
    end

    function automatic string ph_req(input int ph);
        case (ph)
            PH_PIN:  return "R1";
            PH_TRN:  return "R3";
            PH_WAIT: return "R7";
            PH_SEQ:  return "R4";
            PH_SET:  return "R2";
            PH_HOLD: return "R10";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (m_on && $time > 2) begin
            n_rst += int'(sys_rst);
            n_drv += int'(pin_drive);
            n_abt += int'(bus_abort);
            chk(ph_req(m_ph), "sys_rst_o", int'(sys_rst), int'(m_rst));
            chk(ph_req(m_ph), "rstout_n_o", int'(rstout_n), int'(!m_rst));
            chk(ph_req(m_ph), "pin_drive_o", int'(pin_drive), int'(m_drv));
            chk(ph_req(m_ph), "bus_abort_o", int'(bus_abort), int'(m_abt));
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic clr();
        n_rst = 0; n_drv = 0; n_abt = 0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        m_reset();
        m_on = 1'b1;
        #1 ext_n = 1'b0;
        #2;
        // R1: asynchronous entry before any clock edge
        chk("R1", "sys_rst_o async", int'(sys_rst), 1);
        chk("R1", "rstout_n_o async", int'(rstout_n), 0);
        chk("R1", "pin_drive_o async", int'(pin_drive), 0);
        chk("R1", "bus_abort_o async", int'(bus_abort), 0);

        // R2/R3: cold release
        tick(3);
        ext_n = 1'b1; clr();
        tick(SEQ + 12);
        chk("R2", "cold reset cycles", n_rst, SEQ + 6);
        chk("R3", "cold abort cycles", n_abt, 0);

        // R3: warm release with transition phase
        ext_n = 1'b0; warm_mode = 1'b1;
        tick(3);
        ext_n = 1'b1; clr();
        tick(SEQ + TRN + 12);
        chk("R3", "warm abort cycles", n_abt, TRN);
        chk("R3", "warm reset cycles", n_rst, SEQ + TRN + 6);
        warm_mode = 1'b0;

        // R4/R5: software reset
        clr();
        sw_req = 1'b1; tick(); sw_req = 1'b0;
        tick(SEQ + 8);
        chk("R4", "sw reset cycles", n_rst, SEQ + 3);
        chk("R5", "sw drive cycles", n_drv, SEQ);

        // R11: requests absorbed mid-sequence
        clr();
        sw_req = 1'b1; tick(); sw_req = 1'b0;
        tick(5);
        sw_req = 1'b1; wdt_ovf = 1'b1; tick(); sw_req = 1'b0; wdt_ovf = 1'b0;
        tick(SEQ + 6);
        chk("R11", "absorbed reset cycles", n_rst, SEQ + 3);

        // R6: watchdog, idle bus, no bidirectional enable
        clr();
        wdt_ovf = 1'b1; tick(); wdt_ovf = 1'b0;
        tick(SEQ + 8);
        chk("R6", "wdt reset cycles", n_rst, SEQ + 3);
        chk("R6", "wdt drive cycles", n_drv, 0);

        // R9: enable set, then cleared by the sequence end
        bidir_set = 1'b1; tick(); bidir_set = 1'b0;
        clr();
        wdt_ovf = 1'b1; tick(); wdt_ovf = 1'b0;
        tick(SEQ + 8);
        chk("R9", "bidir wdt drive cycles", n_drv, SEQ);
        clr();
        wdt_ovf = 1'b1; tick(); wdt_ovf = 1'b0;
        tick(SEQ + 8);
        chk("R9", "drive after enable cleared", n_drv, 0);

        // R8: bootstrap mode blocks watchdog
        boot_mode = 1'b1; clr();
        wdt_ovf = 1'b1; tick(); wdt_ovf = 1'b0;
        tick(10);
        chk("R8", "boot wdt reset cycles", n_rst, 0);
        boot_mode = 1'b0;

        // R7: READY cycle, READY inactive -> abort
        bus_busy = 1'b1; bus_rdy_used = 1'b1; rdy_n = 1'b1; clr();
        wdt_ovf = 1'b1; tick(); wdt_ovf = 1'b0;
        tick(5);
        chk("R7", "reset while waiting", n_rst, 0);
        bus_ws_done = 1'b1; tick(); bus_ws_done = 1'b0; bus_busy = 1'b0;
        tick(SEQ + 8);
        chk("R7", "abort pulse cycles", n_abt, 1);
        chk("R7", "reset after wait", n_rst, SEQ + 3);

        // R7: READY cycle, READY active -> completes
        bus_busy = 1'b1; rdy_n = 1'b0; clr();
        wdt_ovf = 1'b1; tick(); wdt_ovf = 1'b0;
        tick(3);
        bus_ws_done = 1'b1; tick(); bus_ws_done = 1'b0; bus_busy = 1'b0;
        tick(SEQ + 8);
        chk("R7", "ready-active abort cycles", n_abt, 0);

        // R7: cycle without READY completes even with READY high
        bus_busy = 1'b1; bus_rdy_used = 1'b0; rdy_n = 1'b1; clr();
        wdt_ovf = 1'b1; tick(); wdt_ovf = 1'b0;
        tick(2);
        bus_ws_done = 1'b1; tick(); bus_ws_done = 1'b0; bus_busy = 1'b0;
        tick(SEQ + 8);
        chk("R7", "no-ready abort cycles", n_abt, 0);
        chk("R7", "no-ready reset cycles", n_rst, SEQ + 3);

        // R12: software wins over watchdog
        clr();
        sw_req = 1'b1; wdt_ovf = 1'b1; tick(); sw_req = 1'b0; wdt_ovf = 1'b0;
        tick(SEQ + 8);
        chk("R12", "priority drive cycles", n_drv, SEQ);

        // R10: external hold beyond the sequence
        sw_req = 1'b1; tick(); sw_req = 1'b0;
        tick(5);
        ext_n = 1'b0;
        tick(SEQ + 6);
        chk("R10", "sys_rst_o while held", int'(sys_rst), 1);
        ext_n = 1'b1; clr();
        tick(10);
        chk("R10", "cycles after hold release", n_rst, 3);

        finish_run();
    end

endmodule